// File: doc/BRIEF.md
# Address-Mapped Flash Command Decoder

This block sits on a simple request/response slave bus and turns each access into a flash-controller operation. It decodes every access from its address alone. Bits [25:24] select one of four maps. The lower bits carry either a packed flash address (block, page, sector) or a plain word index. The write data is used only as payload or as a command code. A small behavioural word array stands in for the flash cells. The array holds one main area and one spare area per page.

Data-map accesses stream words through the addressed page using an internal word pointer. The stream covers the main words only, or the main words followed by the spare words when the spare flag is set. Command-map writes start block erases and update a per-block lock table. Lock and unlock ranges are bracketed by a start command and an end command. Register-map accesses reach the status, acknowledge and spare-flag registers. Direct-map accesses read or write array words by flat index, with no lock check.

The control state machine has three states:
- `FSM_IDLE` accepts requests.
- `FSM_PROG_WAIT` is entered from idle when the last word of a data-map write stream is accepted.
- `FSM_ERASE_WAIT` is entered from idle when an erase command targets an unlocked block.

Both wait states return to `FSM_IDLE` after `OP_CYCLES` cycles and set their completion bits. `req_ready` is high only in `FSM_IDLE`.

Top module: `cmdmap_flash_front`

## Requirements
- R1: Address bits [25:24] select the map: 0 direct, 1 data, 2 command, 3 register. With the default layout, the block number is at bit 12, the page at bit 6 and the sector at bit 4 (sector is decoded but does not affect the access). The `LAYOUT`=1 variant places them at bits 10, 4 and 2. A direct access uses the flat array index shifted left by 1; a register access uses the register word shifted left by 2. Flat index = (block*PAGES + page)*(MAIN_WORDS+SPARE_WORDS) + word, with spare words following the main words.
- R2: After reset every block is locked, the status register (register word 0) reads 0, the spare flag (register word 2, bit 0) reads 0, `irq` is 0 and every array word reads 0xFFFFFFFF.
- R3: Data-map accesses to the same block and page step through the words in order and wrap to word 0 after the last word of the stream. The pointer restarts at word 0 whenever the block or page differs from the previous data-map access. With the spare flag clear the stream is MAIN_WORDS long; with it set, the stream continues through the SPARE_WORDS spare words.
- R4: A data-map read of the last word of a stream sets status bit 0 (load done) and bit 3 (block operation done).
- R5: A data-map write stores its word. Accepting the last word of a stream holds `req_ready` low for exactly OP_CYCLES cycles, then sets status bit 1 (program done) and bit 3.
- R6: A command-map write whose low data byte is 0x03 erases the addressed block. `req_ready` is low for OP_CYCLES cycles, then all its words read 0xFFFFFFFF and status bits 2 (erase done) and 3 are set. Other blocks are unchanged.
- R7: Codes 0x08 then 0x09 unlock every block from the start command's block to the end command's block inclusive; codes 0x0A then 0x0B lock that range. An end code whose matching start was not the last range command leaves the lock table unchanged and sets no status. A completed range sets status bit 3.
- R8: Code 0x0E unlocks every block and sets status bit 3.
- R9: A data-map access or erase aimed at a locked block sets status bit 4 (locked). When this happens:
  - a write stores nothing;
  - an erase neither runs nor stalls;
  - a read returns 0;
  - the word pointer does not move.
- R10: Writing register word 1 clears the status bits where the data has 1s and leaves the others. `irq` is high whenever any status bit is set.
- R11: While an operation is in progress, a pending request is not accepted and produces no response until `req_ready` returns high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 26 | Access offset: map in [25:24], flash address or word index below |
| req_wdata | input | 32 | Write payload or command code |
| req_ready | output | 1 | Request accepted on this edge when high with req_valid |
| rsp_valid | output | 1 | Read data valid, one cycle after an accepted read |
| rsp_data | output | 32 | Read data |
| irq | output | 1 | High while any status bit is set |

## Verification
A wrong word pointer shows at the next data-map read as a word from the wrong position. A wrong stream length shows as a misplaced completion bit in the status register, readable one access later. A wrong lock-table entry shows at the first access to that block: either a spurious locked flag, or a write or erase that lands where it must not, which a direct-map read then exposes. A wrong busy count shows as `req_ready` returning one cycle early or late.

// File: rtl/cmf_pkg.sv
package cmf_pkg;

    typedef enum logic [1:0] {
        MAP_DIRECT = 2'd0,
        MAP_DATA   = 2'd1,
        MAP_CMD    = 2'd2,
        MAP_REG    = 2'd3
    } map_e;

    typedef enum logic [1:0] {
        FSM_IDLE       = 2'd0,
        FSM_PROG_WAIT  = 2'd1,
        FSM_ERASE_WAIT = 2'd2
    } fsm_e;

    typedef enum logic [1:0] {
        RNG_NONE   = 2'd0,
        RNG_LOCK   = 2'd1,
        RNG_UNLOCK = 2'd2
    } rng_e;

    localparam logic [7:0] OPC_ERASE      = 8'h03;
    localparam logic [7:0] OPC_UNLK_FIRST = 8'h08;
    localparam logic [7:0] OPC_UNLK_LAST  = 8'h09;
    localparam logic [7:0] OPC_LOCK_FIRST = 8'h0A;
    localparam logic [7:0] OPC_LOCK_LAST  = 8'h0B;
    localparam logic [7:0] OPC_UNLK_EVERY = 8'h0E;

    localparam int SB_LOAD   = 0;
    localparam int SB_PROG   = 1;
    localparam int SB_ERASE  = 2;
    localparam int SB_BLOCK  = 3;
    localparam int SB_LOCKED = 4;
    localparam int STAT_W    = 5;

    localparam int RW_STATUS = 0;
    localparam int RW_ACK    = 1;
    localparam int RW_SPARE  = 2;

endpackage

// File: rtl/cmf_addr_split.sv
module cmf_addr_split
    import cmf_pkg::*;
#(
    parameter int LAYOUT = 0,
    parameter int BLK_W  = 2,
    parameter int PG_W   = 1
) (
    input  logic [25:0]      addr,
    output map_e             map,
    output logic [BLK_W-1:0] blk,
    output logic [PG_W-1:0]  pg,
    output logic [22:0]      direct_word,
    output logic [21:0]      reg_word
);
    assign map         = map_e'(addr[25:24]);
    assign direct_word = addr[23:1];
    assign reg_word    = addr[23:2];

    generate
        if (LAYOUT == 0) begin : g_wide
            localparam int BLK_SH = 12;
            localparam int PG_SH  = 6;
            assign blk = addr[BLK_SH +: BLK_W];
            assign pg  = addr[PG_SH +: PG_W];
        end else begin : g_narrow
            localparam int BLK_SH = 10;
            localparam int PG_SH  = 4;
            assign blk = addr[BLK_SH +: BLK_W];
            assign pg  = addr[PG_SH +: PG_W];
        end
    endgenerate

endmodule

// File: rtl/cmf_lock_table.sv
module cmf_lock_table
    import cmf_pkg::*;
#(
    parameter int BLOCKS = 4,
    parameter int BLK_W  = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_en,
    input  logic [7:0]        cmd_code,
    input  logic [BLK_W-1:0]  cmd_blk,
    output logic [BLOCKS-1:0] locked,
    output logic              range_done
);
    logic [BLOCKS-1:0] locked_q;
    rng_e              pend_q;
    logic [BLK_W-1:0]  start_q;
    logic              end_ok;

    assign locked = locked_q;

    always_comb begin
        end_ok = cmd_en &&
                 (((cmd_code == OPC_UNLK_LAST) && (pend_q == RNG_UNLOCK)) ||
                  ((cmd_code == OPC_LOCK_LAST) && (pend_q == RNG_LOCK)));
        range_done = end_ok || (cmd_en && (cmd_code == OPC_UNLK_EVERY));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            locked_q <= '1;
            pend_q   <= RNG_NONE;
            start_q  <= '0;
        end else if (cmd_en) begin
            case (cmd_code)
                OPC_LOCK_FIRST: begin
                    pend_q  <= RNG_LOCK;
                    start_q <= cmd_blk;
                end
                OPC_UNLK_FIRST: begin
                    pend_q  <= RNG_UNLOCK;
                    start_q <= cmd_blk;
                end
                OPC_LOCK_LAST, OPC_UNLK_LAST: begin
                    if (end_ok) begin
                        for (int b = 0; b < BLOCKS; b++) begin
                            if ((b >= int'(start_q)) && (b <= int'(cmd_blk)))
                                locked_q[b] <= (cmd_code == OPC_LOCK_LAST);
                        end
                    end
                    pend_q <= RNG_NONE;
                end
                OPC_UNLK_EVERY: begin
                    locked_q <= '0;
                    pend_q   <= RNG_NONE;
                end
                default: ;
            endcase
        end
    end

    // R8: unlock-all clears the whole table on the next cycle
    p_unlock_all_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && (cmd_code == OPC_UNLK_EVERY)) |=> (locked_q == '0));

    // R7: a completed lock range covers its own end block
    p_lock_range_end_r7: assert property (@(posedge clk) disable iff (rst)
        (cmd_en && (cmd_code == OPC_LOCK_LAST) && (pend_q == RNG_LOCK) && (start_q <= cmd_blk))
        |=> locked_q[$past(cmd_blk)]);

endmodule

// File: rtl/cmf_array.sv
module cmf_array #(
    parameter int DEPTH     = 48,
    parameter int BLK_WORDS = 12,
    parameter int IDX_W     = 6,
    parameter int BLK_W     = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [31:0]      wdata,
    input  logic             erase_en,
    input  logic [BLK_W-1:0] erase_blk,
    input  logic [IDX_W-1:0] ridx,
    output logic [31:0]      rdata
);
    logic [31:0] mem [DEPTH];

    assign rdata = (int'(ridx) < DEPTH) ? mem[ridx] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
        end else begin
            if (erase_en) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if ((i / BLK_WORDS) == int'(erase_blk)) mem[i] <= '1;
                end
            end
            if (we && (int'(widx) < DEPTH)) mem[widx] <= wdata;
        end
    end

    // R6: first and last word of an erased block are blank afterwards
    p_erase_blank_r6: assert property (@(posedge clk) disable iff (rst)
        (erase_en && !we) |=> ((mem[int'($past(erase_blk)) * BLK_WORDS] == '1) &&
                               (mem[int'($past(erase_blk)) * BLK_WORDS + BLK_WORDS - 1] == '1)));

endmodule

// File: rtl/cmdmap_flash_front.sv
module cmdmap_flash_front
    import cmf_pkg::*;
#(
    parameter int LAYOUT      = 0,
    parameter int BLOCKS      = 4,
    parameter int PAGES       = 2,
    parameter int MAIN_WORDS  = 4,
    parameter int SPARE_WORDS = 2,
    parameter int OP_CYCLES   = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [25:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        req_ready,
    output logic        rsp_valid,
    output logic [31:0] rsp_data,
    output logic        irq
);
    localparam int BLK_W      = (BLOCKS > 1) ? $clog2(BLOCKS) : 1;
    localparam int PG_W       = (PAGES > 1) ? $clog2(PAGES) : 1;
    localparam int PAGE_WORDS = MAIN_WORDS + SPARE_WORDS;
    localparam int BLK_WORDS  = PAGES * PAGE_WORDS;
    localparam int DEPTH      = BLOCKS * BLK_WORDS;
    localparam int IDX_W      = $clog2(DEPTH);
    localparam int PTR_W      = (PAGE_WORDS > 1) ? $clog2(PAGE_WORDS) : 1;
    localparam int CNT_W      = $clog2(OP_CYCLES + 1);

    fsm_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    map_e             map;
    logic [BLK_W-1:0] blk;
    logic [PG_W-1:0]  pg;
    logic [22:0]      direct_word;
    logic [21:0]      reg_word;

    logic [STAT_W-1:0] status_q, st_set, st_clr;
    logic              spare_q;
    logic [PTR_W-1:0]  ptr_q, cur_ptr;
    logic [BLK_W-1:0]  last_blk_q, op_blk_q;
    logic [PG_W-1:0]   last_pg_q;
    logic              ptr_vld_q;

    logic              acc, is_data, is_cmd, data_ok, blk_locked, last_word;
    logic              erase_req, op_last, dir_in_range;
    logic [BLOCKS-1:0] locked;
    logic              range_done;
    logic              mem_we, erase_en;
    logic [IDX_W-1:0]  data_idx, mem_idx;
    logic [31:0]       mem_rdata, rd_val;
    logic [PTR_W-1:0]  limit_m1;

    cmf_addr_split #(.LAYOUT(LAYOUT), .BLK_W(BLK_W), .PG_W(PG_W)) u_split (
        .addr(req_addr), .map(map), .blk(blk), .pg(pg),
        .direct_word(direct_word), .reg_word(reg_word)
    );

    cmf_lock_table #(.BLOCKS(BLOCKS), .BLK_W(BLK_W)) u_locks (
        .clk(clk), .rst(rst),
        .cmd_en(is_cmd && (req_wdata[7:0] != OPC_ERASE)),
        .cmd_code(req_wdata[7:0]), .cmd_blk(blk),
        .locked(locked), .range_done(range_done)
    );

    cmf_array #(.DEPTH(DEPTH), .BLK_WORDS(BLK_WORDS), .IDX_W(IDX_W), .BLK_W(BLK_W)) u_array (
        .clk(clk), .rst(rst),
        .we(mem_we), .widx(mem_idx), .wdata(req_wdata),
        .erase_en(erase_en), .erase_blk(op_blk_q),
        .ridx(mem_idx), .rdata(mem_rdata)
    );

    // Request decode
    always_comb begin
        req_ready  = (state_q == FSM_IDLE);
        acc        = req_valid && req_ready;
        is_data    = acc && (map == MAP_DATA);
        is_cmd     = acc && (map == MAP_CMD) && req_write;
        blk_locked = locked[blk];
        data_ok    = is_data && !blk_locked;
        erase_req  = is_cmd && (req_wdata[7:0] == OPC_ERASE);
        cur_ptr    = (ptr_vld_q && (blk == last_blk_q) && (pg == last_pg_q)) ? ptr_q : '0;
        limit_m1   = spare_q ? PTR_W'(PAGE_WORDS - 1) : PTR_W'(MAIN_WORDS - 1);
        last_word  = (cur_ptr >= limit_m1);
        data_idx   = IDX_W'((int'(blk) * PAGES + int'(pg)) * PAGE_WORDS + int'(cur_ptr));
        dir_in_range = (direct_word < 23'(DEPTH));
        mem_idx    = (map == MAP_DATA) ? data_idx : direct_word[IDX_W-1:0];
        op_last    = (cnt_q == CNT_W'(OP_CYCLES - 1));
    end

    // Next-state process
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FSM_IDLE: begin
                if (data_ok && req_write && last_word) state_d = FSM_PROG_WAIT;
                else if (erase_req && !blk_locked)     state_d = FSM_ERASE_WAIT;
            end
            FSM_PROG_WAIT, FSM_ERASE_WAIT: begin
                if (op_last) state_d = FSM_IDLE;
            end
            default: state_d = FSM_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FSM_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q != FSM_IDLE && !op_last) ? cnt_q + 1'b1 : '0;
        end
    end

    // Output and datapath controls
    always_comb begin
        mem_we   = (data_ok && req_write) ||
                   (acc && (map == MAP_DIRECT) && req_write && dir_in_range);
        erase_en = (state_q == FSM_ERASE_WAIT) && op_last;
        st_set   = '0;
        st_clr   = '0;
        if ((is_data || erase_req) && blk_locked) st_set[SB_LOCKED] = 1'b1;
        if (data_ok && !req_write && last_word) begin
            st_set[SB_LOAD]  = 1'b1;
            st_set[SB_BLOCK] = 1'b1;
        end
        if (range_done) st_set[SB_BLOCK] = 1'b1;
        if (op_last) begin
            unique case (state_q)
                FSM_PROG_WAIT:  begin st_set[SB_PROG]  = 1'b1; st_set[SB_BLOCK] = 1'b1; end
                FSM_ERASE_WAIT: begin st_set[SB_ERASE] = 1'b1; st_set[SB_BLOCK] = 1'b1; end
                default: ;
            endcase
        end
        if (acc && req_write && (map == MAP_REG) && (reg_word == 22'(RW_ACK)))
            st_clr = req_wdata[STAT_W-1:0];
        rd_val = '0;
        unique case (map)
            MAP_DIRECT: rd_val = dir_in_range ? mem_rdata : '0;
            MAP_DATA:   rd_val = blk_locked ? '0 : mem_rdata;
            MAP_CMD:    rd_val = '0;
            MAP_REG: begin
                if (reg_word == 22'(RW_STATUS))     rd_val = 32'(status_q);
                else if (reg_word == 22'(RW_SPARE)) rd_val = 32'(spare_q);
            end
            default: ;
        endcase
        irq = |status_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q   <= '0;
            spare_q    <= 1'b0;
            ptr_q      <= '0;
            ptr_vld_q  <= 1'b0;
            last_blk_q <= '0;
            last_pg_q  <= '0;
            op_blk_q   <= '0;
            rsp_valid  <= 1'b0;
            rsp_data   <= '0;
        end else begin
            status_q  <= (status_q & ~st_clr) | st_set;
            rsp_valid <= acc && !req_write;
            if (acc && !req_write) rsp_data <= rd_val;
            if (acc && req_write && (map == MAP_REG) && (reg_word == 22'(RW_SPARE)))
                spare_q <= req_wdata[0];
            if (data_ok) begin
                ptr_q      <= last_word ? '0 : cur_ptr + 1'b1;
                ptr_vld_q  <= 1'b1;
                last_blk_q <= blk;
                last_pg_q  <= pg;
            end
            if (erase_req) op_blk_q <= blk;
        end
    end

    // R11: no response follows a cycle in which requests were refused
    p_stall_no_rsp_r11: assert property (@(posedge clk) disable iff (rst)
        !req_ready |=> !rsp_valid);

    // R10: acknowledging every bit leaves the status register empty
    p_ack_all_clears_r10: assert property (@(posedge clk) disable iff (rst)
        (acc && req_write && (map == MAP_REG) && (reg_word == 22'(RW_ACK)) &&
         (req_wdata[STAT_W-1:0] == '1)) |=> (status_q == '0));

    // R9: a data access to a locked block raises the locked flag
    p_locked_flag_r9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (map == MAP_DATA) && locked[blk]) |=> status_q[SB_LOCKED]);

    // R5: a program wait always ends with the program-done bit
    p_prog_done_r5: assert property (@(posedge clk) disable iff (rst)
        ((state_q == FSM_PROG_WAIT) && (state_d == FSM_IDLE)) |=> status_q[SB_PROG]);

endmodule

// File: tb/cmdmap_flash_front_tb.sv
module cmdmap_flash_front_tb_top;

    localparam int BLOCKS = 4;
    localparam int PAGES  = 2;
    localparam int MAINW  = 4;
    localparam int SPAREW = 2;
    localparam int OPC    = 6;
    localparam int PW     = MAINW + SPAREW;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [25:0] req_addr  = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, rsp_valid, irq;
    logic [31:0] rsp_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    cmdmap_flash_front #(.LAYOUT(0), .BLOCKS(BLOCKS), .PAGES(PAGES), .MAIN_WORDS(MAINW),
                         .SPARE_WORDS(SPAREW), .OP_CYCLES(OPC)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .irq(irq)
    );

    function automatic logic [25:0] a_data(int b, int p, int s);
        return 26'((1 << 24) | (b << 12) | (p << 6) | (s << 4));
    endfunction
    function automatic logic [25:0] a_cmd(int b);
        return 26'((2 << 24) | (b << 12));
    endfunction
    function automatic logic [25:0] a_reg(int w);
        return 26'((3 << 24) | (w << 2));
    endfunction
    function automatic logic [25:0] a_dir(int idx);
        return 26'(idx << 1);
    endfunction
    function automatic logic [31:0] pat(int b, int p, int i);
        return 32'hC000_0000 | 32'(b << 16) | 32'(p << 8) | 32'(i);
    endfunction
    function automatic int flat(int b, int p, int i);
        return (b * PAGES + p) * PW + i;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [25:0] a, input logic [31:0] d,
                        output logic [31:0] q);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        q = rsp_data;
        if (!wr) chk("R11 rsp_valid after read", 32'(rsp_valid), 32'd1);
    endtask

    task automatic wr(input logic [25:0] a, input logic [31:0] d);
        logic [31:0] q;
        xfer(1'b1, a, d, q);
    endtask

    task automatic rd(input logic [25:0] a, output logic [31:0] q);
        xfer(1'b0, a, 32'd0, q);
    endtask

    task automatic expect_status(input string req, input logic [31:0] exp);
        logic [31:0] q;
        rd(a_reg(0), q);
        chk(req, q, exp);
        chk({req, " irq"}, 32'(irq), 32'(exp != 0));
        wr(a_reg(1), 32'h1F);
    endtask

    // Counts refused cycles while a status read waits; no response may appear meanwhile
    task automatic busy_then_status(output int cycles, output logic [31:0] st, output int stray);
        cycles = 0; stray = 0;
        req_valid = 1'b1; req_write = 1'b0; req_addr = a_reg(0); req_wdata = '0;
        while (!req_ready) begin
            cycles++;
            if (rsp_valid) stray++;
            @(negedge clk);
        end
        @(negedge clk);
        req_valid = 1'b0;
        st = rsp_data;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] q, st;
        int cyc, stray;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R2: reset state
        chk("R2 irq after reset", 32'(irq), 32'd0);
        rd(a_reg(0), q); chk("R2 status after reset", q, 32'd0);
        rd(a_reg(2), q); chk("R2 spare flag after reset", q, 32'd0);
        for (int i = 0; i < BLOCKS * PAGES * PW; i += 7) begin
            rd(a_dir(i), q); chk("R2 array blank", q, 32'hFFFF_FFFF);
        end
        for (int b = 0; b < BLOCKS; b++) begin
            rd(a_data(b, 0, 0), q);
            chk("R9 read of locked block returns 0", q, 32'd0);
            expect_status("R2 all blocks locked (bit4)", 32'h10);
        end

        // R8: unlock all
        wr(a_cmd(0), 32'h0E);
        expect_status("R8 unlock-all sets bit3", 32'h08);

        // R5 R11 R1 R4: program and read back every page
        for (int b = 0; b < BLOCKS; b++) begin
            for (int p = 0; p < PAGES; p++) begin
                for (int i = 0; i < MAINW - 1; i++) wr(a_data(b, p, 0), pat(b, p, i));
                wr(a_data(b, p, 0), pat(b, p, MAINW - 1));
                busy_then_status(cyc, st, stray);
                chk("R5 program busy cycles", 32'(cyc), 32'(OPC));
                chk("R11 no response while busy", 32'(stray), 32'd0);
                chk("R5 program status bits1,3", st, 32'h0A);
                wr(a_reg(1), 32'h1F);
                for (int i = 0; i < MAINW; i++) begin
                    rd(a_dir(flat(b, p, i)), q);
                    chk("R1 direct index of programmed word", q, pat(b, p, i));
                end
                for (int i = 0; i < MAINW; i++) begin
                    rd(a_data(b, p, 3), q);
                    chk("R3 stream read order", q, pat(b, p, i));
                end
                expect_status("R4 load done bits0,3", 32'h09);
                rd(a_dir(flat(b, p, MAINW)), q);
                chk("R3 spare untouched without flag", q, 32'hFFFF_FFFF);
            end
        end

        // R3: pointer restart and wrap
        rd(a_data(0, 0, 0), q); chk("R3 word0", q, pat(0, 0, 0));
        rd(a_data(0, 0, 0), q); chk("R3 word1", q, pat(0, 0, 1));
        rd(a_data(1, 0, 0), q); chk("R3 restart on block change", q, pat(1, 0, 0));
        rd(a_data(0, 0, 0), q); chk("R3 restart on return", q, pat(0, 0, 0));
        rd(a_data(0, 1, 0), q); chk("R3 restart on page change", q, pat(0, 1, 0));
        for (int i = 1; i < MAINW; i++) begin
            rd(a_data(0, 1, 0), q); chk("R3 stream continues", q, pat(0, 1, i));
        end
        rd(a_data(0, 1, 0), q); chk("R3 wrap after main words", q, pat(0, 1, 0));
        wr(a_reg(1), 32'h1F);

        // R3 R5: spare stream
        wr(a_reg(2), 32'd1);
        rd(a_reg(2), q); chk("R3 spare flag readback", q, 32'd1);
        for (int i = 0; i < PW - 1; i++) wr(a_data(3, 1, 0), 32'hA500_0000 | 32'(i));
        rd(a_reg(0), q); chk("R5 no program before last spare word", q, 32'd0);
        wr(a_data(3, 1, 0), 32'hA500_0000 | 32'(PW - 1));
        busy_then_status(cyc, st, stray);
        chk("R5 busy cycles with spare", 32'(cyc), 32'(OPC));
        chk("R5 status with spare", st, 32'h0A);
        wr(a_reg(1), 32'h1F);
        for (int i = 0; i < SPAREW; i++) begin
            rd(a_dir(flat(3, 1, MAINW + i)), q);
            chk("R3 spare word stored", q, 32'hA500_0000 | 32'(MAINW + i));
        end
        for (int i = 0; i < PW; i++) begin
            rd(a_data(3, 1, 0), q); chk("R3 spare stream read", q, 32'hA500_0000 | 32'(i));
        end
        rd(a_data(3, 1, 0), q); chk("R3 wrap after spare", q, 32'hA500_0000);
        wr(a_reg(2), 32'd0);
        wr(a_reg(1), 32'h1F);

        // R6: erase block 1
        wr(a_cmd(1), 32'h03);
        busy_then_status(cyc, st, stray);
        chk("R6 erase busy cycles", 32'(cyc), 32'(OPC));
        chk("R6 erase status bits2,3", st, 32'h0C);
        wr(a_reg(1), 32'h1F);
        for (int i = 0; i < PAGES * PW; i++) begin
            rd(a_dir(flat(1, 0, i)), q); chk("R6 erased word", q, 32'hFFFF_FFFF);
        end
        rd(a_dir(flat(0, 1, 3)), q); chk("R6 neighbour block kept", q, pat(0, 1, 3));
        rd(a_dir(flat(2, 0, 0)), q); chk("R6 neighbour block kept", q, pat(2, 0, 0));

        // R7: lock range 1..2
        wr(a_cmd(1), 32'h0A);
        rd(a_reg(0), q); chk("R7 start alone sets nothing", q, 32'd0);
        wr(a_cmd(2), 32'h0B);
        expect_status("R7 range done bit3", 32'h08);
        wr(a_data(1, 0, 0), 32'h1234_5678);
        rd(a_dir(flat(1, 0, 0)), q); chk("R9 locked write not stored", q, 32'hFFFF_FFFF);
        expect_status("R9 locked write flag", 32'h10);
        wr(a_cmd(2), 32'h03);
        chk("R9 locked erase does not stall", 32'(req_ready), 32'd1);
        rd(a_dir(flat(2, 0, 0)), q); chk("R9 locked erase no effect", q, pat(2, 0, 0));
        expect_status("R9 locked erase flag", 32'h10);
        rd(a_data(3, 0, 0), q); chk("R7 block past range open", q, pat(3, 0, 0));
        rd(a_data(0, 0, 0), q); chk("R7 block before range open", q, pat(0, 0, 0));
        expect_status("R7 open blocks no flag", 32'h00);

        // R7: end code without start
        wr(a_cmd(1), 32'h09);
        rd(a_reg(0), q); chk("R7 orphan end sets nothing", q, 32'd0);
        rd(a_data(1, 0, 0), q); chk("R9 still locked read 0", q, 32'd0);
        expect_status("R7 orphan end leaves lock", 32'h10);

        // R7: unlock range of one block
        wr(a_cmd(1), 32'h08);
        wr(a_cmd(1), 32'h09);
        rd(a_data(1, 0, 0), q); chk("R7 single-block unlock", q, 32'hFFFF_FFFF);
        rd(a_data(2, 0, 0), q); chk("R7 block 2 stays locked", q, 32'd0);
        expect_status("R7 unlock done plus lock flag", 32'h18);

        // R9: locked read does not move pointer
        rd(a_data(0, 0, 0), q); chk("R9 setup word0", q, pat(0, 0, 0));
        rd(a_data(0, 0, 0), q); chk("R9 setup word1", q, pat(0, 0, 1));
        rd(a_data(2, 0, 0), q); chk("R9 locked read", q, 32'd0);
        rd(a_data(0, 0, 0), q); chk("R9 pointer kept after locked access", q, pat(0, 0, 2));
        wr(a_reg(1), 32'h1F);

        // R10: partial acknowledge
        wr(a_cmd(3), 32'h03);
        busy_then_status(cyc, st, stray);
        chk("R6 erase block 3 status", st, 32'h0C);
        wr(a_reg(1), 32'h04);
        rd(a_reg(0), q); chk("R10 partial ack keeps bit3", q, 32'h08);
        chk("R10 irq while bit set", 32'(irq), 32'd1);
        wr(a_reg(1), 32'h08);
        rd(a_reg(0), q); chk("R10 ack clears remaining", q, 32'd0);
        chk("R10 irq low after ack", 32'(irq), 32'd0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule